// File: doc/BRIEF.md
# Serial Programming Port Target

This block is the device end of a two-wire programming link. An external host provides a programming clock and a single data line that changes direction. The host sends frames of twenty clocks: a 4-bit command, then a 16-bit operand. The block decodes two instructions of the core-instruction command. One loads a literal into a working register. The other copies that register into one of the three bytes of a 22-bit table pointer. This gives the host a way to place the pointer anywhere in the address space.

A table-read command returns the byte at the pointer and then advances the pointer. The operand of this command is split into two halves:

- During the first half, the data line stays an input and the byte is fetched.
- During the second half, after a turnaround gap in which the host holds the clock low, the block drives the byte out one bit per clock.

Both pins are brought into the block's own system clock through two-flop synchronizers. All edges are found in that clock domain, so the host clock must be much slower than the system clock.

Top module: `pgm_port_target`

## Requirements
- R1: While `rst_n` is low, `pdat_oe` is 0. After reset the table pointer and the working register are 0, and the next frame starts at its first command bit.
- R2: `pdat_in` is sampled on each falling edge of `pclk_in`. A frame is 20 falling edges. The first 4 form the command, least significant bit first. The next 16 form the operand, least significant bit first, so bits 15..8 of the operand are the opcode byte and bits 7..0 are the argument byte.
- R3: In a frame with command 4'b0000 and an opcode byte of 8'h0E, the argument byte is written into the working register.
- R4: In a frame with command 4'b0000 and an opcode byte of 8'h6E, the working register is copied into part of the pointer, chosen by the argument byte. 8'hF8 selects pointer bits 21:16 (taking working-register bits 5:0), 8'hF7 selects bits 15:8 and 8'hF6 selects bits 7:0. Any other argument byte leaves the pointer unchanged.
- R5: In a frame with command 4'b1001, `pdat_oe` stays 0 through the 4 command clocks, the first 8 operand clocks and the following low gap. It goes to 1 on the rising edge of the 9th operand clock.
- R6: In a table read, bit k (k = 0..7) of the fetched byte appears on `pdat_out` at the rising edge of operand clock 9+k. It holds until the next rising edge.
- R7: `pdat_oe` returns to 0 on the falling edge of the 16th operand clock. The pin is then an input for the next frame.
- R8: The byte is fetched on the falling edge of the 8th operand clock of a table read. At the same edge the pointer is incremented by one, wrapping from 22'h3FFFFF to 0.
- R9: A pointer below 256 reads the byte (a*37 + 8'h5B) mod 256, where a is the pointer value. Any other pointer value reads 8'hFF.
- R10: A frame with any other command code, or a core-instruction frame with any other opcode byte, changes neither the pointer, the working register nor the pins.
- R11: Any effect of a `pclk_in` transition appears at the third rising edge of `clk` after the transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample both programming pins |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk_in | input | 1 | Programming clock from the host |
| pdat_in | input | 1 | Data pin value as seen from the pad |
| pdat_out | output | 1 | Data pin value driven during a read |
| pdat_oe | output | 1 | Data pin output enable |

## Verification
Every programming clock transition reaches the state at the third system-clock edge after it. The bench therefore holds each programming clock phase for six system clocks. It samples the returned bit and the output enable in the last system cycle of the phase, before the host moves the clock again. A behavioural model in the bench sees the pins through the same two-cycle delay and is compared with the outputs at every falling system-clock edge. The delay itself is checked once, at the first rising edge of a data phase: the enable must still be low one edge before the third edge and high just after it. Returned bytes are compared with values computed from a host-side copy of the pointer.

// File: rtl/pgm_port_target.sv
module pgm_port_target #(
  parameter int          PTR_W    = 22,
  parameter int          MEM_AW   = 8,
  parameter logic [7:0]  FILL_MUL = 8'd37,
  parameter logic [7:0]  FILL_ADD = 8'h5B
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pclk_in,
  input  logic pdat_in,
  output logic pdat_out,
  output logic pdat_oe
);
  localparam int CNT_W = 5;
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [CNT_W-1:0] CMD_END  = CNT_W'(4);
  localparam logic [CNT_W-1:0] FETCH_AT = CNT_W'(11);
  localparam logic [CNT_W-1:0] SEND_AT  = CNT_W'(12);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(19);
  localparam logic [3:0] C_CORE = 4'b0000;
  localparam logic [3:0] C_TRD  = 4'b1001;
  localparam logic [7:0] OP_LIT = 8'h0E;
  localparam logic [7:0] OP_STO = 8'h6E;
  localparam logic [7:0] SEL_UP = 8'hF8;
  localparam logic [7:0] SEL_HI = 8'hF7;
  localparam logic [7:0] SEL_LO = 8'hF6;

  logic [2:0]       ck_s;
  logic [1:0]       dt_s;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       cmd;
  logic [15:0]      op;
  logic [7:0]       wreg;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rsh;
  logic [7:0]       mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign mem[i] = 8'(i * FILL_MUL + FILL_ADD);
  end

  wire        rise    = ck_s[1] & ~ck_s[2];
  wire        fall    = ~ck_s[1] & ck_s[2];
  wire        din     = dt_s[1];
  wire [15:0] op_nx   = {din, op[15:1]};
  wire [3:0]  cmd_nx  = {din, cmd[3:1]};
  wire        is_trd  = (cmd == C_TRD);
  wire        in_mem  = (ptr >> MEM_AW) == '0;
  wire [7:0]  rd_byte = in_mem ? mem[ptr[MEM_AW-1:0]] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
    end else begin
      ck_s <= {ck_s[1:0], pclk_in};
      dt_s <= {dt_s[0], pdat_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmd      <= '0;
      op       <= '0;
      wreg     <= '0;
      ptr      <= '0;
      rsh      <= '0;
      pdat_oe  <= 1'b0;
      pdat_out <= 1'b0;
    end else if (fall) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (cnt < CMD_END) cmd <= cmd_nx;
      else               op  <= op_nx;
      if (is_trd && cnt == FETCH_AT) begin
        rsh <= rd_byte;
        ptr <= ptr + 1'b1;
      end
      if (cnt == LAST) begin
        pdat_oe <= 1'b0;
        if (cmd == C_CORE) begin
          if (op_nx[15:8] == OP_LIT) wreg <= op_nx[7:0];
          else if (op_nx[15:8] == OP_STO) begin
            case (op_nx[7:0])
              SEL_UP:  ptr[PTR_W-1:16] <= wreg[PTR_W-17:0];
              SEL_HI:  ptr[15:8]       <= wreg;
              SEL_LO:  ptr[7:0]        <= wreg;
              default: ;
            endcase
          end
        end
      end
    end else if (rise && is_trd && cnt >= SEND_AT) begin
      pdat_oe  <= 1'b1;
      pdat_out <= rsh[0];
      rsh      <= {1'b0, rsh[7:1]};
    end
  end
endmodule

// File: rtl/pgm_port_target_chk.sv
module pgm_port_target_chk #(
  parameter int PTR_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             fall,
  input logic [4:0]       cnt,
  input logic [3:0]       cmd,
  input logic [7:0]       wreg,
  input logic [PTR_W-1:0] ptr,
  input logic             pdat_oe,
  input logic             pdat_out
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (!pdat_oe && ptr == '0 && wreg == '0));

  a_r5_no_early_drive: assert property (@(posedge clk) disable iff (!rst_n)
    pdat_oe |-> (cnt >= 5'd12 && cmd == 4'b1001));

  a_r6_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(pdat_out));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cnt == 5'd19) |=> !pdat_oe);

  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cnt == 5'd11 && cmd == 4'b1001) |=> (ptr == $past(ptr) + 1'b1));

  a_r10_other_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cnt == 5'd19 && cmd != 4'b0000) |=> ($stable(wreg) && $stable(ptr)));
endmodule

bind pgm_port_target pgm_port_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cnt(cnt), .cmd(cmd),
  .wreg(wreg), .ptr(ptr), .pdat_oe(pdat_oe), .pdat_out(pdat_out)
);

// File: tb/pgm_port_target_bench.sv
module pgm_port_target_bench;
  localparam int H = 6;
  localparam int GAP = 8;
  localparam int PMOD = 1 << 22;

  logic clk = 0, rst_n = 0, pclk_in = 0, pdat_in = 0;
  logic pdat_out, pdat_oe;
  int total = 0, bad = 0;
  int hp = 0;

  always #10 clk = ~clk;

  pgm_port_target u_pgm_port_target (
    .clk(clk), .rst_n(rst_n), .pclk_in(pclk_in), .pdat_in(pdat_in),
    .pdat_out(pdat_out), .pdat_oe(pdat_oe)
  );

  function automatic int memf(int a);
    return (a < 256) ? ((a * 37 + 91) % 256) : 255;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, seeing pins through two sampling stages
  int m_c1, m_c2, m_c3, m_d1, m_d2, m_cnt, m_cmd, m_op, m_w, m_p, m_rb, m_oe, m_do;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_c1 = 0; m_c2 = 0; m_c3 = 0; m_d1 = 0; m_d2 = 0; m_cnt = 0; m_cmd = 0;
      m_op = 0; m_w = 0; m_p = 0; m_rb = 0; m_oe = 0; m_do = 0;
    end else begin
      if (!m_c2 && m_c3) begin
        m_cnt++;
        if (m_cnt <= 4) m_cmd = m_cmd | (m_d2 << (m_cnt - 1));
        else m_op = m_op | (m_d2 << (m_cnt - 5));
        if (m_cnt == 12 && m_cmd == 9) begin
          m_rb = memf(m_p);
          m_p = (m_p + 1) % PMOD;
        end
        if (m_cnt == 20) begin
          m_oe = 0;
          if (m_cmd == 0) begin
            if (m_op / 256 == 'h0E) m_w = m_op % 256;
            else if (m_op / 256 == 'h6E) begin
              if (m_op % 256 == 'hF8) m_p = (m_p % 65536) + (m_w % 64) * 65536;
              if (m_op % 256 == 'hF7) m_p = m_p - ((m_p / 256) % 256) * 256 + m_w * 256;
              if (m_op % 256 == 'hF6) m_p = m_p - (m_p % 256) + m_w;
            end
          end
          m_cnt = 0; m_cmd = 0; m_op = 0;
        end
      end else if (m_c2 && !m_c3 && m_cmd == 9 && m_cnt >= 12) begin
        m_oe = 1;
        m_do = (m_rb >> (m_cnt - 12)) & 1;
      end
      m_c3 = m_c2; m_c2 = m_c1; m_c1 = pclk_in;
      m_d2 = m_d1; m_d1 = pdat_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(pdat_oe == m_oe[0], "R5/R7 model oe", pdat_oe, m_oe);
    if (m_oe != 0) check(pdat_out == m_do[0], "R6 model bit", pdat_out, m_do);
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(bit b);
    pclk_in = 1; pdat_in = b; hold(H);
    pclk_in = 0; hold(H);
  endtask

  task automatic cmd4(logic [3:0] c);
    for (int i = 0; i < 4; i++) bit_out(c[i]);
  endtask

  task automatic core(logic [15:0] o);
    cmd4(4'b0000);
    for (int i = 0; i < 16; i++) bit_out(o[i]);
  endtask

  task automatic set_ptr(int a);
    core(16'h0E00 | 16'((a >> 16) & 255)); core(16'h6EF8);
    core(16'h0E00 | 16'((a >> 8) & 255));  core(16'h6EF7);
    core(16'h0E00 | 16'(a & 255));         core(16'h6EF6);
    hp = a % PMOD;
  endtask

  task automatic read_byte(string tag, bit lat);
    logic [7:0] got;
    int exp;
    cmd4(4'b1001);
    for (int i = 0; i < 8; i++) begin
      bit_out(1'b1);
      if (i < 7) check(pdat_oe == 0, "R5 oe during input half", pdat_oe, 0);
    end
    hold(GAP);
    check(pdat_oe == 0, "R5 oe in gap", pdat_oe, 0);
    for (int k = 0; k < 8; k++) begin
      pclk_in = 1;
      if (k == 0 && lat) begin
        hold(2); check(pdat_oe == 0, "R11 two edges after rise", pdat_oe, 0);
        hold(1); check(pdat_oe == 1, "R11 third edge after rise", pdat_oe, 1);
        hold(H - 3);
      end else hold(H);
      check(pdat_oe == 1, "R5 oe while sending", pdat_oe, 1);
      got[k] = pdat_out;
      pclk_in = 0; hold(H);
    end
    check(pdat_oe == 0, "R7 oe after 16th operand clock", pdat_oe, 0);
    exp = memf(hp);
    check(got == 8'(exp), tag, got, exp);
    hp = (hp + 1) % PMOD;
  endtask

  initial begin
    hold(5);
    check(pdat_oe == 0, "R1 oe in reset", pdat_oe, 0);
    rst_n = 1;
    hold(3);
    read_byte("R1 R9 first read at pointer 0", 1'b1);
    read_byte("R8 R6 next byte", 1'b0);
    set_ptr('h10);
    read_byte("R4 R9 read 0x10", 1'b0);
    read_byte("R8 read 0x11", 1'b0);
    set_ptr('hFF);
    read_byte("R9 last in-memory byte", 1'b0);
    read_byte("R9 0x100 reads FF", 1'b0);
    set_ptr('h3FFFFF);
    read_byte("R9 top of range reads FF", 1'b0);
    read_byte("R8 wrap to 0", 1'b0);
    set_ptr('h0100FE);
    read_byte("R4 upper byte set reads FF", 1'b0);
    core(16'h0EC0); core(16'h6EF8);
    core(16'h0E00); core(16'h6EF7);
    core(16'h0E05); core(16'h6EF6);
    hp = 5;
    read_byte("R4 upper takes 6 bits, R3 literal", 1'b0);
    core(16'h0E40);
    cmd4(4'b0101);
    for (int i = 0; i < 16; i++) bit_out(i < 8 ? ((8'hF6 >> i) & 1) : ((8'h6E >> (i - 8)) & 1));
    core(16'h6E12);
    core(16'h2AF6);
    check(pdat_oe == 0, "R10 pin idle after other frames", pdat_oe, 0);
    read_byte("R10 pointer untouched by other frames", 1'b0);
    core(16'h6EF6);
    hp = 'h40;
    read_byte("R3 R2 working register value stored", 1'b0);
    hold(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R2 frame never completed actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule